// File: doc/BRIEF.md
# Decade Rate Multiplier

This block divides a clock stream by ten and passes a chosen number of those ten clocks through to its rate output. A 4-bit decimal select word `sel` picks how many: with `sel` = 6, six separate pulses leave `rate_o` in every run of ten input clocks. Each pulse is the low half of one input clock cycle, so a pulse begins on a falling clock edge and ends on the next rising edge. Pulses are never merged, because every clock that is let through is framed by its own clock high phase.

An internal decade counter steps 0 through 9 on the rising edge. Each select bit is tied to its own group of counter states: bit 3 to eight states, bit 2 to four, bit 1 to two and bit 0 to one. The pulse in a cycle is the OR of the groups whose bits are set. A terminal count output marks the counter's last state. Controls give an asynchronous clear, a synchronous load to nine, an active-low count enable, a strobe that blocks the rate pulses and a cascade input that holds the true rate output high. Codes 10 to 15 have a defined result of eight or nine pulses.

Top module: `bcd_rate_mult`

## Requirements
- R1: With `sel` = N in 0..9, `ce_n` low and all other controls low, `rate_o` shows exactly N rising edges in any ten consecutive clock cycles.
- R2: `rate_o` can be high only while `clk` is low: it is low in every high phase, and in a selected cycle it is high during the low phase that follows.
- R3: A high `clr` puts the counter in state 0 at once, with no clock edge, so `tc_o` drops before the next edge. It overrides `rst_n`, `preset` and `ce_n`. While the counter is held in state 0 with `sel` = 8, `rate_o` pulses in every cycle, which is 10 per ten clocks.
- R4: `preset` high at a rising edge loads state 9, so `tc_o` is high after that edge, whatever `ce_n` is. `clr` takes priority over `preset`.
- R5: With `ce_n` high the counter keeps its state. `tc_o` does not change, and the rate output keeps following the held state: held state 9 gives 0 pulses for any `sel`, and held state 0 with `sel` = 8 gives a pulse every cycle.
- R6: `strobe` high with `cascade` low keeps `rate_o` low and `rate_n` high.
- R7: `cascade` high holds `rate_o` high, including while `strobe` is high. With `strobe` low, `rate_n` keeps showing N falling edges per ten clocks.
- R8: While counting, `tc_o` is high for exactly one cycle in every ten (state 9), and `tc_n` is always the inverse of `tc_o`.
- R9: Select codes 10, 12 and 14 give 8 pulses per ten clocks. Codes 11, 13 and 15 give 9.
- R10: With `cascade` low, `rate_n` is the exact inverse of `rate_o`.
- R11: `rst_n` low at a rising edge puts the counter in state 0. After release, `tc_o` rises on the ninth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; counter steps on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to state 0 |
| clr | input | 1 | Asynchronous clear to state 0, highest priority |
| ce_n | input | 1 | Count enable, active low |
| preset | input | 1 | Synchronous load of state 9 |
| strobe | input | 1 | Inhibits the rate pulses |
| cascade | input | 1 | Holds `rate_o` high |
| sel | input | 4 | Decimal rate select word |
| rate_o | output | 1 | Rate pulses, active high |
| rate_n | output | 1 | Complementary rate output |
| tc_o | output | 1 | Terminal count, high in state 9 |
| tc_n | output | 1 | Terminal count, active low |

## Verification
The counter state and the terminal count change one rising edge after the control that causes them. The only exception is `clr`, which acts with no edge, so the bench checks it 1 ns after driving it, while `clk` is still low. Rate pulses appear during the low phase of the same cycle in which the state is reached. The bench therefore counts rate edges over windows of exactly ten rising edges, and it takes level samples 1 ns after a falling edge (pulse phase) or 1 ns after a rising edge (blank phase). All stimulus is applied 1 ns after a rising edge, so every window covers exactly ten counter states.

// File: rtl/rm_pkg.sv
// Package for the decade rate multiplier: the counter width, the counter
// modulus and the rule that assigns counter states to each select bit.
// Assumes a 4-bit decimal select word and a count from 0 to MODULUS-1.
package rm_pkg;
    localparam int DIGIT_W  = 4;
    localparam int MODULUS  = 10;
    localparam int LAST     = MODULUS - 1;
    localparam int GATED_HI = 8;          // states below this feed bits 3..1

    typedef logic [DIGIT_W-1:0] digit_t;

    // Tells whether counter state s belongs to the group of select bit w.
    // Group sizes are 8, 4, 2 and 1. Groups for bits 2 and 1 lie inside
    // the group for bit 3. Bits 2, 1 and 0 have no shared state.
    function automatic logic slot_hit(input int w, input digit_t s);
        logic low8;
        low8 = (int'(s) < GATED_HI);
        case (w)
            3:       slot_hit = low8;
            2:       slot_hit = low8 && s[0];
            1:       slot_hit = low8 && (s[1:0] == 2'b10);
            default: slot_hit = (int'(s) == GATED_HI);
        endcase
    endfunction
endpackage

// File: rtl/rm_decade_counter.sv
// Decade counter with an asynchronous clear, a synchronous reset, a load of
// the last state and an active-low enable. Priority: clr, rst_n, preset,
// ce_n. Assumes clr is released away from the rising clock edge.
module rm_decade_counter
    import rm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   ce_n,
    input  logic   preset,
    output digit_t state,
    output logic   at_last
);
    localparam digit_t FIRST_ST = digit_t'(0);
    localparam digit_t LAST_ST  = digit_t'(LAST);

    digit_t state_q;

    // Counter register: clears at once on clr, steps on the rising edge otherwise.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state_q <= FIRST_ST;
        end else if (!rst_n) begin
            state_q <= FIRST_ST;
        end else if (preset) begin
            state_q <= LAST_ST;
        end else if (!ce_n) begin
            state_q <= (state_q == LAST_ST) ? FIRST_ST : state_q + digit_t'(1);
        end
    end

    // Terminal state decode.
    always_comb begin
        at_last = (state_q == LAST_ST);
    end

    assign state = state_q;
endmodule

// File: rtl/rm_pulse_select.sv
// Combines the select word with the counter state. Each select bit enables
// its own group of states, and the result is the OR over all bits.
// Assumes the state is stable during the low phase of the clock.
module rm_pulse_select
    import rm_pkg::*;
(
    input  digit_t sel,
    input  digit_t state,
    output logic   pick
);
    logic [DIGIT_W-1:0] hit;

    // One gate per select bit, each tied to its own group of states.
    for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
        always_comb begin
            hit[b] = sel[b] & slot_hit(b, state);
        end
    end

    // Merge the per-bit results.
    always_comb begin
        pick = |hit;
    end
endmodule

// File: rtl/rm_out_gate.sv
// Output stage. It lets a selected cycle through as the low half of the
// clock and applies strobe and cascade. Assumes state and pick change
// only while clk is high.
module rm_out_gate (
    input  logic clk,
    input  logic pick,
    input  logic strobe,
    input  logic cascade,
    output logic rate_o,
    output logic rate_n
);
    logic gated;

    // Clock-phase gating with the strobe inhibit.
    always_comb begin
        gated = pick & ~strobe & ~clk;
    end

    // True output takes the cascade override; the complement does not.
    always_comb begin
        rate_o = gated | cascade;
        rate_n = ~gated;
    end
endmodule

// File: rtl/bcd_rate_mult.sv
// Top of the decade rate multiplier. Passes N of every ten input clocks to
// the rate output, with terminal count, preset, clear, strobe and cascade.
// Assumes inputs change while clk is high, away from both edges.
module bcd_rate_mult
    import rm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ce_n,
    input  logic               preset,
    input  logic               strobe,
    input  logic               cascade,
    input  logic [DIGIT_W-1:0] sel,
    output logic               rate_o,
    output logic               rate_n,
    output logic               tc_o,
    output logic               tc_n
);
    digit_t state;
    logic   at_last;
    logic   pick;

    rm_decade_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ce_n    (ce_n),
        .preset  (preset),
        .state   (state),
        .at_last (at_last)
    );

    rm_pulse_select u_sel (
        .sel   (sel),
        .state (state),
        .pick  (pick)
    );

    rm_out_gate u_out (
        .clk     (clk),
        .pick    (pick),
        .strobe  (strobe),
        .cascade (cascade),
        .rate_o  (rate_o),
        .rate_n  (rate_n)
    );

    // Terminal count pair.
    always_comb begin
        tc_o = at_last;
        tc_n = ~at_last;
    end
endmodule

// File: rtl/rm_checker.sv
// Checker for the decade rate multiplier, attached to the top module with bind.
module rm_checker (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic ce_n,
    input logic preset,
    input logic cascade,
    input logic rate_o,
    input logic tc_o,
    input logic tc_n
);
    assert_tc_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o == ~tc_n);

    assert_tc_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !ce_n && !preset && !clr) |=> (!tc_o || clr));

    assert_preset_nine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !clr) |=> (tc_o || clr));

    assert_hold_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !preset && !clr) |=> ($stable(tc_o) || clr));

    assert_clear_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !tc_o);

    assert_cascade_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |-> rate_o);
endmodule

bind bcd_rate_mult rm_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .ce_n    (ce_n),
    .preset  (preset),
    .cascade (cascade),
    .rate_o  (rate_o),
    .tc_o    (tc_o),
    .tc_n    (tc_n)
);

// File: tb/sim_bcd_rate_mult.sv
module sim_bcd_rate_mult;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       ce_n = 1'b0;
    logic       preset = 1'b0;
    logic       strobe = 1'b0;
    logic       cascade = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       rate_o, rate_n, tc_o, tc_n;

    int errors = 0;
    int checks = 0;
    int rise_cnt = 0;
    int fall_n_cnt = 0;

    bcd_rate_mult u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ce_n(ce_n), .preset(preset),
        .strobe(strobe), .cascade(cascade), .sel(sel),
        .rate_o(rate_o), .rate_n(rate_n), .tc_o(tc_o), .tc_n(tc_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge rate_o) rise_cnt++;
    always @(negedge rate_n) fall_n_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Counts rate edges over ten rising edges, starting just after an edge.
    task automatic window(output int rises, output int nfalls);
        int r0, f0;
        r0 = rise_cnt;
        f0 = fall_n_cnt;
        repeat (10) @(posedge clk);
        #1;
        rises = rise_cnt - r0;
        nfalls = fall_n_cnt - f0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        chk("R11 tc_o in reset", tc_o, 0);
        chk("R11 tc_n in reset", tc_n, 1);
        rst_n = 1'b1;
        repeat (8) step();
        chk("R11 tc_o after 8 edges", tc_o, 0);
        step();
        chk("R11 tc_o after 9 edges", tc_o, 1);
    endtask

    task automatic t_rates();
        int r, f;
        for (int n = 0; n < 16; n++) begin
            sel = 4'(n);
            window(r, f);
            if (n < 10) chk($sformatf("R1 pulses sel=%0d", n), r, n);
            else        chk($sformatf("R9 pulses sel=%0d", n), r, n[0] ? 9 : 8);
        end
    endtask

    task automatic t_phase_inverse();
        int bad;
        bad = 0;
        sel = 4'd5;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            if (rate_n !== ~rate_o) bad++;
        end
        chk("R10 rate_n inverse mismatches", bad, 0);
        step();
    endtask

    task automatic t_tc_period();
        int hi, bad;
        hi = 0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (tc_o) hi++;
            if (tc_o === tc_n) bad++;
        end
        chk("R8 tc_o high cycles in 20", hi, 2);
        chk("R8 tc pair mismatches", bad, 0);
    endtask

    task automatic t_hold_and_clear();
        int r, f;
        preset = 1'b1;
        step();
        preset = 1'b0;
        ce_n = 1'b1;
        chk("R4 tc_o after preset", tc_o, 1);
        sel = 4'd15;
        window(r, f);
        chk("R5 pulses while held at 9", r, 0);
        chk("R5 tc_o held", tc_o, 1);
        @(negedge clk);
        #1;
        clr = 1'b1;
        #1;
        chk("R3 tc_o low before edge", tc_o, 0);
        sel = 4'd8;
        @(negedge clk);
        #1;
        chk("R2 rate_o in low phase", rate_o, 1);
        step();
        chk("R2 rate_o in high phase", rate_o, 0);
        clr = 1'b0;
        window(r, f);
        chk("R5 pulses held at 0 sel=8", r, 10);
        chk("R5 tc_o held low", tc_o, 0);
        preset = 1'b1;
        step();
        preset = 1'b0;
        chk("R4 preset overrides disabled count", tc_o, 1);
        ce_n = 1'b0;
    endtask

    task automatic t_clear_priority();
        int r, f;
        ce_n = 1'b1;
        clr = 1'b1;
        preset = 1'b1;
        sel = 4'd8;
        step();
        chk("R3 clr over preset", tc_o, 0);
        window(r, f);
        chk("R3 sel=8 under clear", r, 10);
        clr = 1'b0;
        step();
        chk("R4 preset after clr release", tc_o, 1);
        preset = 1'b0;
        ce_n = 1'b0;
    endtask

    task automatic t_strobe_cascade();
        int r, f;
        sel = 4'd9;
        strobe = 1'b1;
        window(r, f);
        chk("R6 rate_o pulses under strobe", r, 0);
        chk("R6 rate_n pulses under strobe", f, 0);
        @(negedge clk);
        #1;
        chk("R6 rate_n level under strobe", rate_n, 1);
        chk("R6 rate_o level under strobe", rate_o, 0);
        step();
        cascade = 1'b1;
        @(negedge clk);
        #1;
        chk("R7 cascade over strobe", rate_o, 1);
        step();
        strobe = 1'b0;
        sel = 4'd6;
        window(r, f);
        chk("R7 rate_n pulses with cascade", f, 6);
        chk("R7 rate_o rises with cascade", r, 0);
        chk("R7 rate_o level with cascade", rate_o, 1);
        cascade = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_rates();
        t_phase_inverse();
        t_tc_period();
        t_hold_and_clear();
        t_clear_priority();
        t_strobe_cascade();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule